// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block sends one command at a time to a power-management controller through three memory-mapped mailbox registers, then returns that controller's answer. A client hands over a 4-bit message ID and a 32-bit argument on a valid/ready request port. The sequencer then works through a fixed series of register accesses on its master port. It clears the status register to the busy code 0x0, loads the argument register, and writes the message ID last. Writing the ID is what starts the command on the far side.

After the trigger, the sequencer reads the status register until the value is nonzero. Between reads it waits a programmable number of microseconds, counted in clock cycles. The number of extra reads is limited by a programmable retry budget. Once a nonzero status arrives, the sequencer reads the argument register again, because the controller writes the value it actually applied there. It then reports the low status byte and that value with a one-cycle `done` pulse. If the budget runs out, it reports a timeout. Two messages, 0x8 and 0x9, are withheld when the cached controller version is older than a threshold. In that case they complete at once with an all-ones answer.

Back-pressure applies only to the request port. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the client must hold its fields stable until then. The result side has no back-pressure: `done` is a pulse, and the client must capture `done_result`, `done_data` and `done_timeout` in that cycle. Status codes used by the controller are 0x01 OK, 0xFF failed, 0xFE unknown command, 0xFD missing prerequisite, and 0xFC busy. The block passes them through without interpreting them. Typical settings are a 10 µs delay and a budget of 200000.

Top module: `mbx_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `bus_req` is 0 and `done` is 0.
- R2: A sent command performs three writes in this exact order: 0x0 to the status register (address `A_STAT`, default 0x5B), the argument to the argument register (`A_ARG`, default 0x53), then the message ID zero-extended to 32 bits to the message register (`A_MSG`, default 0x43).
- R3: After the trigger, the block reads `A_STAT` until it reads a nonzero value. `done_result` is then bits 7:0 of that value.
- R4: Between two status reads of one command, at least `CYC_PER_US * cfg_delay_us` clock cycles pass, and no bus request is made in that time.
- R5: A command makes at most `cfg_retries + 1` status reads. If all of them return 0, the `done` pulse carries `done_timeout` = 1, `done_result` = 0x00 and `done_data` = 0, and `A_ARG` is not read.
- R6: After a nonzero status, the block reads `A_ARG` once and returns the value read on `done_data`, with `done_timeout` = 0.
- R7: Message IDs 0x8 and 0x9 are withheld when `fw_version` < `MIN_VER` (default 0x370C00). In that case no bus access occurs, and `done` rises in the cycle after acceptance with `done_result` = 0x00 and `done_data` = 0xFFFFFFFF. When `fw_version` >= `MIN_VER`, these messages are sent normally.
- R8: `req_ready` is 0 from acceptance until after `done`. A `req_valid` raised during that time has no effect: no extra bus traffic and no extra `done`.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high. Read data is taken from `bus_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_msg | input | 4 | Message ID |
| req_arg | input | 32 | Command argument |
| fw_version | input | 32 | Cached controller version used for withholding |
| cfg_delay_us | input | 16 | Wait between status reads, in microseconds |
| cfg_retries | input | 18 | Extra status reads allowed after the first |
| done | output | 1 | One-cycle completion pulse |
| done_result | output | 8 | Status byte (0x00 on timeout or withheld) |
| done_data | output | 32 | Returned argument value |
| done_timeout | output | 1 | Budget exhausted, qualified by done |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The hardest states to reach from the ports are the ones where the sequencer must keep retrying. These are reads of 0 between waits, and a budget that runs out on exactly its last read. A responder model in the bench answers only after a set number of zero reads, or never, and the bench records each register access with its cycle number. This lets the spacing of status reads, the total read count and the absence of an argument read on timeout be checked. A second hard case is a request held valid while a command is waiting between polls. The bench raises it in the middle of a long wait and then counts message writes and `done` pulses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_ARG,
    ST_TRIG,
    ST_POLL,
    ST_WAIT,
    ST_FETCH,
    ST_DONE
  } mbx_state_t;

  localparam logic [7:0] STAT_BUSY = 8'h00;
endpackage

// File: rtl/mbx_bus_mux.sv
module mbx_bus_mux
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MSG_W  = 4,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h5B,
  parameter logic [ADDR_W-1:0] A_ARG  = 8'h53,
  parameter logic [ADDR_W-1:0] A_MSG  = 8'h43
) (
  input  mbx_state_t        state,
  input  logic [DATA_W-1:0] arg,
  input  logic [MSG_W-1:0]  msg,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_CLR:   begin req = 1'b1; we = 1'b1; addr = A_STAT; end
      ST_ARG:   begin req = 1'b1; we = 1'b1; addr = A_ARG; wdata = arg; end
      ST_TRIG:  begin req = 1'b1; we = 1'b1; addr = A_MSG;
                      wdata = DATA_W'(msg); end
      ST_POLL:  begin req = 1'b1; addr = A_STAT; end
      ST_FETCH: begin req = 1'b1; addr = A_ARG; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int CYC_PER_US = 125,
  parameter int DLY_W      = 16,
  parameter int RETRY_W    = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clr,
  input  logic               bump,
  input  logic [DLY_W-1:0]   delay_us,
  input  logic [RETRY_W-1:0] retries,
  output logic               expired,
  output logic               spent
);
  localparam int CNT_W = DLY_W + $clog2(CYC_PER_US + 1);

  logic [CNT_W-1:0]   cnt;
  logic [RETRY_W-1:0] used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(CYC_PER_US) * CNT_W'(delay_us);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    used <= '0;
    else if (clr)  used <= '0;
    else if (bump) used <= used + 1'b1;
  end

  assign expired = (cnt == '0);
  assign spent   = (used == retries);

  // R4: the wait counter only moves downward one step at a time unless reloaded
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int DLY_W      = 16,
  parameter int RETRY_W    = 18,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MSG_W      = 4,
  parameter int RES_W      = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h5B,
  parameter logic [ADDR_W-1:0] A_ARG  = 8'h53,
  parameter logic [ADDR_W-1:0] A_MSG  = 8'h43,
  parameter logic [MSG_W-1:0]  GATE_A = 4'h8,
  parameter logic [MSG_W-1:0]  GATE_B = 4'h9,
  parameter logic [31:0]       MIN_VER = 32'h0037_0C00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [MSG_W-1:0]   req_msg,
  input  logic [DATA_W-1:0]  req_arg,
  input  logic [31:0]        fw_version,
  input  logic [DLY_W-1:0]   cfg_delay_us,
  input  logic [RETRY_W-1:0] cfg_retries,
  output logic               done,
  output logic [RES_W-1:0]   done_result,
  output logic [DATA_W-1:0]  done_data,
  output logic               done_timeout,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata
);
  mbx_state_t        state;
  logic [MSG_W-1:0]  msg_q;
  logic [DATA_W-1:0] arg_q;
  logic [RES_W-1:0]  res_q;
  logic [DATA_W-1:0] data_q;
  logic              tmo_q;
  logic              accept, gated, hit;
  logic              t_load, t_clr, t_bump, t_expired, t_spent;

  assign accept = req_valid && (state == ST_IDLE);
  assign gated  = ((req_msg == GATE_A) || (req_msg == GATE_B)) &&
                  (fw_version < MIN_VER);
  assign hit    = bus_req && bus_ack;

  mbx_bus_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_W(MSG_W),
    .A_STAT(A_STAT), .A_ARG(A_ARG), .A_MSG(A_MSG)
  ) u_mux (
    .state(state), .arg(arg_q), .msg(msg_q),
    .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata)
  );

  assign t_clr  = accept;
  assign t_bump = (state == ST_POLL) && hit &&
                  (bus_rdata == '0) && !t_spent;
  assign t_load = t_bump;

  mbx_poll_timer #(
    .CYC_PER_US(CYC_PER_US), .DLY_W(DLY_W), .RETRY_W(RETRY_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .clr(t_clr), .bump(t_bump),
    .delay_us(cfg_delay_us), .retries(cfg_retries),
    .expired(t_expired), .spent(t_spent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      msg_q  <= '0;
      arg_q  <= '0;
      res_q  <= '0;
      data_q <= '0;
      tmo_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          msg_q <= req_msg;
          arg_q <= req_arg;
          tmo_q <= 1'b0;
          if (gated) begin
            res_q  <= STAT_BUSY;
            data_q <= '1;
            state  <= ST_DONE;
          end else begin
            state <= ST_CLR;
          end
        end
        ST_CLR:  if (hit) state <= ST_ARG;
        ST_ARG:  if (hit) state <= ST_TRIG;
        ST_TRIG: if (hit) state <= ST_POLL;
        ST_POLL: if (hit) begin
          if (bus_rdata != '0) begin
            res_q <= bus_rdata[RES_W-1:0];
            state <= ST_FETCH;
          end else if (t_spent) begin
            res_q  <= STAT_BUSY;
            data_q <= '0;
            tmo_q  <= 1'b1;
            state  <= ST_DONE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (t_expired) state <= ST_POLL;
        ST_FETCH: if (hit) begin
          data_q <= bus_rdata;
          state  <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign done         = (state == ST_DONE);
  assign done_result  = res_q;
  assign done_data    = data_q;
  assign done_timeout = tmo_q;

  // R10: request and its fields held until acknowledged
  a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_we) && $stable(bus_wdata)));
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: once accepted, not ready on the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R7: withheld message finishes next cycle with all-ones and no bus traffic
  a_r7_withheld: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gated) |=> (done && (done_data == '1) && !bus_req));
  // R5: a timeout carries a zero status byte
  a_r5_timeout_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> (done_result == '0));
endmodule

// File: tb/sim_mbx_seq.sv
module sim_mbx_seq;
  localparam int CYC = 125;
  localparam logic [7:0] A_STAT = 8'h5B, A_ARG = 8'h53, A_MSG = 8'h43;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_msg = '0;
  logic [31:0] req_arg = '0;
  logic [31:0] fw_version = 32'h0037_0C00;
  logic [15:0] cfg_delay_us = 16'd1;
  logic [17:0] cfg_retries = 18'd3;
  logic        done, done_timeout;
  logic [7:0]  done_result;
  logic [31:0] done_data;
  logic        bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  mbx_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_msg(req_msg), .req_arg(req_arg), .fw_version(fw_version),
    .cfg_delay_us(cfg_delay_us), .cfg_retries(cfg_retries),
    .done(done), .done_result(done_result), .done_data(done_data),
    .done_timeout(done_timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responder model
  logic [31:0] r_stat = '0, r_arg = '0;
  int  r_polls = 0, r_pend = 0, r_delta = 0;
  logic [7:0] r_code = 8'h01;
  bit  r_never = 0;
  logic [39:0] wlog[$];
  int  stat_reads = 0, arg_reads = 0, last_read_cyc = -1, min_gap = 1 << 30;

  initial bus_ack = 1'b0;
  initial bus_rdata = '0;
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wlog.push_back({bus_addr, bus_wdata});
        if (bus_addr == A_STAT) r_stat <= bus_wdata;
        if (bus_addr == A_ARG)  r_arg  <= bus_wdata;
        if (bus_addr == A_MSG) begin
          r_pend <= r_polls;
          r_arg  <= r_arg + r_delta;
        end
      end else if (bus_addr == A_STAT) begin
        stat_reads++;
        if (last_read_cyc >= 0 && cyc - last_read_cyc < min_gap)
          min_gap = cyc - last_read_cyc;
        last_read_cyc = cyc;
        if (r_never || r_pend > 0) begin
          r_pend <= r_pend - 1;
          bus_rdata <= r_stat;
        end else begin
          r_stat <= {24'h0, r_code};
          bus_rdata <= {24'h0, r_code};
        end
      end else begin
        arg_reads++;
        bus_rdata <= r_arg;
      end
    end
  end

  // scoreboard
  logic [40:0] exp_q[$];
  string       tag_q[$];
  int          done_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected done", 1, 0);
      end else begin
        logic [40:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({done_timeout, done_result, done_data} == e, t,
            {done_timeout, done_result, done_data}, e);
      end
    end
  end

  task automatic reset_resp(input int polls, input logic [7:0] code, input int delta, input bit never);
    r_polls = polls; r_code = code; r_delta = delta; r_never = never;
    wlog.delete(); stat_reads = 0; arg_reads = 0; last_read_cyc = -1; min_gap = 1 << 30;
  endtask

  task automatic send(input logic [3:0] m, input logic [31:0] a, input logic [40:0] e, input string t);
    int start;
    exp_q.push_back(e);
    tag_q.push_back(t);
    while (!req_ready) @(negedge clk);
    start = done_cnt;
    req_msg = m; req_arg = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == start) @(negedge clk);
  endtask

  task automatic chk_order(input logic [3:0] m, input logic [31:0] a);
    chk(wlog.size() == 3, "R2 write count", wlog.size(), 3);
    if (wlog.size() == 3) begin
      chk(wlog[0] == {A_STAT, 32'h0}, "R2 first write", wlog[0], {A_STAT, 32'h0});
      chk(wlog[1] == {A_ARG, a}, "R2 second write", wlog[1], {A_ARG, a});
      chk(wlog[2] == {A_MSG, 28'h0, m}, "R2 third write", wlog[2], {A_MSG, 28'h0, m});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(bus_req == 1'b0, "R1 bus idle", bus_req, 0);
    chk(done == 1'b0, "R1 done low", done, 0);

    // immediate answer, set clock 100 MHz -> 103
    reset_resp(0, 8'h01, 3, 0);
    send(4'h4, 32'd100, {1'b0, 8'h01, 32'd103}, "R6 reply value");
    chk_order(4'h4, 32'd100);
    chk(stat_reads == 1, "R3 single poll", stat_reads, 1);
    chk(arg_reads == 1, "R6 one arg read", arg_reads, 1);

    // three zero polls then unknown-command code
    reset_resp(3, 8'hFE, 0, 0);
    send(4'h2, 32'h0, {1'b0, 8'hFE, 32'h0}, "R3 status byte");
    chk(stat_reads == 4, "R3 poll count", stat_reads, 4);
    chk(min_gap >= CYC, "R4 poll spacing", min_gap, CYC);

    // display count 0 with failed code, delay zero
    cfg_delay_us = 16'd0;
    reset_resp(2, 8'hFF, 0, 0);
    send(4'hC, 32'h0, {1'b0, 8'hFF, 32'h0}, "R3 failed code");
    chk(stat_reads == 3, "R4 zero delay polls", stat_reads, 3);
    cfg_delay_us = 16'd1;

    // withheld
    fw_version = 32'h0037_0BFF;
    reset_resp(0, 8'h01, 0, 0);
    send(4'h8, 32'd50, {1'b0, 8'h00, 32'hFFFF_FFFF}, "R7 withheld msg 8");
    chk(wlog.size() == 0, "R7 no bus writes", wlog.size(), 0);
    send(4'h9, 32'd50, {1'b0, 8'h00, 32'hFFFF_FFFF}, "R7 withheld msg 9");
    chk(stat_reads + arg_reads == 0, "R7 no bus reads", stat_reads + arg_reads, 0);
    fw_version = 32'h0037_0C00;
    reset_resp(0, 8'h01, 1, 0);
    send(4'h9, 32'd50, {1'b0, 8'h01, 32'd51}, "R7 sent at threshold");
    chk_order(4'h9, 32'd50);

    // timeout
    reset_resp(0, 8'h01, 0, 1);
    send(4'h3, 32'h0, {1'b1, 8'h00, 32'h0}, "R5 timeout report");
    chk(stat_reads == 4, "R5 read budget", stat_reads, 4);
    chk(arg_reads == 0, "R5 no arg read", arg_reads, 0);

    // request during busy is ignored
    reset_resp(2, 8'h01, 0, 0);
    exp_q.push_back({1'b0, 8'h01, 32'd7});
    tag_q.push_back("R8 busy ignore result");
    begin
      int start;
      start = done_cnt;
      req_msg = 4'h7; req_arg = 32'd7; req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 not ready", req_ready, 0);
      req_msg = 4'h5; req_arg = 32'd99;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
      while (done_cnt == start) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(done_cnt == start + 1, "R9 one done", done_cnt - start, 1);
      chk_order(4'h7, 32'd7);
    end
    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule